// File: doc/BRIEF.md
# Synchronous Clock-Stop and Power-Down Gater

This block sits between free-running internal clock sources and the pins that carry them off chip. It forwards one differential CPU clock pair and a parameterised set of single-ended lane clocks, such as bus, graphics-port, USB, reference and memory clocks. Each output can be stopped by its own enable bit from a register file. An active-low power-down input stops all of them together. Every stop and restart happens only at a clock boundary, so an output never shows a pulse shorter than half a period of its source.

A strap sampled during reset selects one of two CPU-pair styles. In the low-stop style, power-down parks every output low, including both CPU lines. Once all outputs have stopped, the block drops its PLL enable flag and then its oscillator enable flag. In the park style, power-down holds the CPU true line driven high and releases the complement. A register bit can instead release both CPU lines. The park style also holds every output stopped until the first falling edge of an active-low power-good input. The frequency-select straps are captured on that edge, and later edges of power-good have no effect.

Top module: `cg_clk_gater`

## Requirements
- R1: A power-down request is accepted only after `pd_n` is sampled low on two consecutive rising edges of `cpu_clk`; a low lasting a single sample has no effect on any output.
- R2: An accepted power-down is released only after `pd_n` is sampled high on two consecutive rising edges of `cpu_clk`; a single high sample leaves every output stopped.
- R3: Stopping and restarting are glitch-free: no high or low pulse on any lane output or on `cpu_t` is shorter than half a period of its source clock.
- R4: With `lane_en[i]` = 0, lane output i stays low while every lane whose bit is 1 keeps toggling.
- R5: In the low-stop style (`strap_mode` = 0 at reset), power-down parks every lane, `cpu_t` and `cpu_c` low with both drive enables at 1. After all outputs have stopped, `pll_en` and then `osc_en` go to 0. Both return to 1 after the power-down is released. Both are 1 during reset.
- R6: In the park style (`strap_mode` = 1) with `park_hiz` = 0, power-down holds every lane low and drives `cpu_t` = 1 with `cpu_t_oe` = 1, while `cpu_c_oe` = 0. `pll_en` stays 1.
- R7: In the park style with `park_hiz` = 1, power-down sets both `cpu_t_oe` and `cpu_c_oe` to 0.
- R8: `mode_park` equals the value of `strap_mode` sampled during reset, and it ignores later changes of the strap.
- R9: In the park style, every output stays stopped after reset until the first 1-to-0 transition of `pwrgd_n`. `fs_sel` takes the value of `strap_fs` at that transition, and later transitions of `pwrgd_n` change neither `fs_sel` nor the outputs.
- R10: In the low-stop style, `fs_sel` is captured from `strap_fs` during reset, `pwrgd_n` is ignored, and the outputs run right after reset.
- R11: `all_stopped` is 1 exactly when every lane and the CPU pair are in their stopped or parked state. It is 1 during reset.
- R12: With `cpu_en` = 0 and no power-down, `cpu_t` and `cpu_c` stay low with both drive enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held for several cycles of the slowest source |
| cpu_clk | input | 1 | Free-running CPU source clock; also the control clock |
| lane_clk | input | N_LANE | Free-running source clock of each lane |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| pwrgd_n | input | 1 | Active-low power-good; meaningful in the park style only |
| strap_mode | input | 1 | CPU-pair style strap: 0 low-stop, 1 park |
| strap_fs | input | FS_W | Frequency-select straps |
| lane_en | input | N_LANE | Per-lane run enable, 1 = running |
| cpu_en | input | 1 | CPU pair run enable, 1 = running |
| park_hiz | input | 1 | Park style: 1 releases both CPU lines during power-down |
| cpu_t | output | 1 | CPU clock, true line |
| cpu_c | output | 1 | CPU clock, complement line |
| cpu_t_oe | output | 1 | Drive enable of `cpu_t` |
| cpu_c_oe | output | 1 | Drive enable of `cpu_c` |
| lane_out | output | N_LANE | Gated lane clocks |
| all_stopped | output | 1 | Every output is stopped or parked |
| pll_en | output | 1 | PLL enable flag |
| osc_en | output | 1 | Oscillator enable flag |
| mode_park | output | 1 | Latched CPU-pair style |
| fs_sel | output | FS_W | Latched frequency select |

## Verification
On every cycle, the in-line assertions check four things: the two-sample qualification of power-down in both directions, the fixed style and one-time frequency capture after reset, that the PLL and oscillator flags fall only as a consequence of an accepted low-stop power-down, and that the complement line is released only in the park style. Only the bench scenarios can show the clock-level properties. Those are which lanes actually toggle for a given mix of enables and power-down, the minimum width of every high and low pulse across stops and restarts, the park levels and drive enables, and the wait for power-good.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

  // Style of the CPU pair during power-down, chosen by a reset-time strap.
  typedef enum logic {
    CPU_MODE_LOWSTOP = 1'b0,
    CPU_MODE_PARK    = 1'b1
  } cpu_mode_e;

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= (chain << 1) | STAGES'(d);
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cg_pd_qual.sv
`timescale 1ns/1ps
module cg_pd_qual (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic pd_acc
);

  logic last_q;
  logic acc_q;

  // The accepted state follows the request only when two samples agree.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b1;
      acc_q  <= 1'b0;
    end else begin
      last_q <= pd_n;
      if (pd_n == last_q) acc_q <= ~pd_n;
    end
  end

  assign pd_acc = acc_q;

  AST_PD_TWO_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_q) |-> (!$past(pd_n) && !$past(pd_n, 2))); // R1

  AST_PD_TWO_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(acc_q) |-> ($past(pd_n) && $past(pd_n, 2))); // R2

endmodule

// File: rtl/cg_strap.sv
`timescale 1ns/1ps
module cg_strap
  import cg_pkg::*;
#(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_mode,
  input  logic [FS_W-1:0] strap_fs,
  input  logic            pwrgd_n,
  output cpu_mode_e       mode,
  output logic [FS_W-1:0] fs,
  output logic            hold
);

  cpu_mode_e       mode_q;
  logic [FS_W-1:0] fs_q;
  logic            armed_q;
  logic            pg_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= cpu_mode_e'(strap_mode);
      fs_q      <= strap_fs;
      armed_q   <= strap_mode;
      pg_prev_q <= pwrgd_n;
    end else begin
      pg_prev_q <= pwrgd_n;
      // The first falling edge of power-good captures the straps once.
      if (armed_q && pg_prev_q && !pwrgd_n) begin
        fs_q    <= strap_fs;
        armed_q <= 1'b0;
      end
    end
  end

  assign mode = mode_q;
  assign fs   = fs_q;
  assign hold = armed_q;

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(mode_q)); // R8

  AST_FS_ONCE: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && $past(!armed_q) && $past(!rst)) |-> $stable(fs_q)); // R9

  AST_ARM_STYLE: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (mode_q == CPU_MODE_PARK)); // R10

endmodule

// File: rtl/cg_lane.sv
`timescale 1ns/1ps
module cg_lane #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst,
  input  logic stop_req,
  output logic clk_out,
  output logic stopped
);

  logic stop_s;
  logic run_q;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (src_clk),
    .rst (rst),
    .d   (stop_req),
    .q   (stop_s)
  );

  // Updated while the source is low: stop after a full high phase, restart
  // with the next complete rising edge.
  always_ff @(negedge src_clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= ~stop_s;
  end

  assign clk_out = src_clk & run_q;
  assign stopped = ~run_q;

endmodule

// File: rtl/cg_cpu_pair.sv
`timescale 1ns/1ps
module cg_cpu_pair (
  input  logic clk,
  input  logic rst,
  input  logic stop_low,
  input  logic park,
  input  logic park_hiz,
  output logic t,
  output logic c,
  output logic t_oe,
  output logic c_oe,
  output logic stopped
);

  logic park_q;
  logic hiz_q;
  logic run_q;

  // The park state changes while the true line is high, so it is never cut.
  always_ff @(posedge clk) begin
    if (rst) begin
      park_q <= 1'b0;
      hiz_q  <= 1'b0;
    end else begin
      park_q <= park;
      hiz_q  <= park_hiz;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= ~stop_low;
  end

  assign t       = park_q | (clk & run_q);
  assign c       = ~park_q & ~clk & run_q;
  assign t_oe    = ~(park_q & hiz_q);
  assign c_oe    = ~park_q;
  assign stopped = park_q | ~run_q;

endmodule

// File: rtl/cg_clk_gater.sv
`timescale 1ns/1ps
module cg_clk_gater
  import cg_pkg::*;
#(
  parameter int N_LANE      = 6,
  parameter int FS_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst,
  input  logic              cpu_clk,
  input  logic [N_LANE-1:0] lane_clk,
  input  logic              pd_n,
  input  logic              pwrgd_n,
  input  logic              strap_mode,
  input  logic [FS_W-1:0]   strap_fs,
  input  logic [N_LANE-1:0] lane_en,
  input  logic              cpu_en,
  input  logic              park_hiz,
  output logic              cpu_t,
  output logic              cpu_c,
  output logic              cpu_t_oe,
  output logic              cpu_c_oe,
  output logic [N_LANE-1:0] lane_out,
  output logic              all_stopped,
  output logic              pll_en,
  output logic              osc_en,
  output logic              mode_park,
  output logic [FS_W-1:0]   fs_sel
);

  cpu_mode_e         mode;
  logic              hold;
  logic              pd_acc;
  logic              is_park;
  logic [N_LANE-1:0] lane_stopped;
  logic              cpu_stopped;
  logic              stopped_s;
  logic              pll_q;
  logic              osc_q;

  cg_pd_qual u_qual (
    .clk    (cpu_clk),
    .rst    (rst),
    .pd_n   (pd_n),
    .pd_acc (pd_acc)
  );

  cg_strap #(.FS_W(FS_W)) u_strap (
    .clk        (cpu_clk),
    .rst        (rst),
    .strap_mode (strap_mode),
    .strap_fs   (strap_fs),
    .pwrgd_n    (pwrgd_n),
    .mode       (mode),
    .fs         (fs_sel),
    .hold       (hold)
  );

  assign is_park   = (mode == CPU_MODE_PARK);
  assign mode_park = is_park;

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    cg_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .src_clk  (lane_clk[i]),
      .rst      (rst),
      .stop_req (pd_acc | ~lane_en[i] | hold),
      .clk_out  (lane_out[i]),
      .stopped  (lane_stopped[i])
    );
  end

  cg_cpu_pair u_cpu (
    .clk      (cpu_clk),
    .rst      (rst),
    .stop_low (~cpu_en | hold | (pd_acc & ~is_park)),
    .park     (pd_acc & is_park & ~hold),
    .park_hiz (park_hiz),
    .t        (cpu_t),
    .c        (cpu_c),
    .t_oe     (cpu_t_oe),
    .c_oe     (cpu_c_oe),
    .stopped  (cpu_stopped)
  );

  assign all_stopped = (&lane_stopped) & cpu_stopped;

  cg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stop_sync (
    .clk (cpu_clk),
    .rst (rst),
    .d   (all_stopped),
    .q   (stopped_s)
  );

  // Low-stop style: PLL goes off after every output is stopped, oscillator after that.
  always_ff @(posedge cpu_clk) begin
    if (rst) begin
      pll_q <= 1'b1;
      osc_q <= 1'b1;
    end else begin
      pll_q <= ~(pd_acc & ~is_park & stopped_s);
      osc_q <= pll_q;
    end
  end

  assign pll_en = pll_q;
  assign osc_en = osc_q;

  AST_PLL_OFF_CAUSE: assert property (@(posedge cpu_clk) disable iff (rst)
    !pll_en |-> ($past(pd_acc) && !is_park)); // R5

  AST_OSC_OFF_CAUSE: assert property (@(posedge cpu_clk) disable iff (rst)
    !osc_en |-> $past(pd_acc, 2)); // R5

  AST_CPU_RELEASE_STYLE: assert property (@(posedge cpu_clk) disable iff (rst)
    !cpu_c_oe |-> is_park); // R6

  AST_TRUE_RELEASE_STYLE: assert property (@(posedge cpu_clk) disable iff (rst)
    !cpu_t_oe |-> (is_park && !cpu_c_oe)); // R7

endmodule

// File: tb/sim_cg_clk_gater.sv
`timescale 1ns/1ps
module sim_cg_clk_gater;

  localparam int N   = 6;
  localparam int FSW = 4;
  localparam int HALF [N] = '{15, 8, 10, 35, 5, 7};

  // Table: [15:10] lane_en, [9] cpu_en, [8] pd_n,
  //        [7:2] lanes expected running, [1] cpu expected running, [0] all_stopped
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {6'h3F, 1'b1, 1'b1, 6'h3F, 1'b1, 1'b0},
    {6'h15, 1'b1, 1'b1, 6'h15, 1'b1, 1'b0},
    {6'h2A, 1'b0, 1'b1, 6'h2A, 1'b0, 1'b0},
    {6'h00, 1'b0, 1'b1, 6'h00, 1'b0, 1'b1},
    {6'h3F, 1'b1, 1'b0, 6'h00, 1'b0, 1'b1},
    {6'h3F, 1'b1, 1'b1, 6'h3F, 1'b1, 1'b0},
    {6'h01, 1'b1, 1'b0, 6'h00, 1'b0, 1'b1},
    {6'h3F, 1'b0, 1'b1, 6'h3F, 1'b0, 1'b0}
  };

  logic           rst = 1'b1;
  logic           cpu_clk = 1'b0;
  logic [N-1:0]   lclk;
  logic           pd_n = 1'b1;
  logic           pwrgd_n = 1'b1;
  logic           strap_mode = 1'b0;
  logic [FSW-1:0] strap_fs = '0;
  logic [N-1:0]   lane_en = '1;
  logic           cpu_en = 1'b1;
  logic           park_hiz = 1'b0;
  logic           cpu_t, cpu_c, cpu_t_oe, cpu_c_oe;
  logic [N-1:0]   lane_out;
  logic           all_stopped, pll_en, osc_en, mode_park;
  logic [FSW-1:0] fs_sel;

  int checks = 0;
  int errors = 0;
  bit mon = 1'b0;
  int lcnt [N];
  int viol [N];
  int ccnt = 0;
  int cviol = 0;
  int snap [N];
  int dif [N];
  int csnap, cdif;

  always #5 cpu_clk = ~cpu_clk;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic c = 1'b0;
    always #(HALF[i]) c = ~c;
    assign lclk[i] = c;

    realtime tr = 0.0;
    realtime tf = 0.0;
    always @(posedge lane_out[i]) begin
      lcnt[i]++;
      if (mon && ($realtime - tf) < (HALF[i] - 0.001)) viol[i]++;
      tr = $realtime;
    end
    always @(negedge lane_out[i]) begin
      if (mon && ($realtime - tr) < (HALF[i] - 0.001)) viol[i]++;
      tf = $realtime;
    end
  end

  realtime ctr = 0.0;
  realtime ctf = 0.0;
  always @(posedge cpu_t) begin
    ccnt++;
    if (mon && ($realtime - ctf) < 4.999) cviol++;
    ctr = $realtime;
  end
  always @(negedge cpu_t) begin
    if (mon && ($realtime - ctr) < 4.999) cviol++;
    ctf = $realtime;
  end

  cg_clk_gater #(.N_LANE(N), .FS_W(FSW), .SYNC_STAGES(2)) u0 (
    .rst         (rst),
    .cpu_clk     (cpu_clk),
    .lane_clk    (lclk),
    .pd_n        (pd_n),
    .pwrgd_n     (pwrgd_n),
    .strap_mode  (strap_mode),
    .strap_fs    (strap_fs),
    .lane_en     (lane_en),
    .cpu_en      (cpu_en),
    .park_hiz    (park_hiz),
    .cpu_t       (cpu_t),
    .cpu_c       (cpu_c),
    .cpu_t_oe    (cpu_t_oe),
    .cpu_c_oe    (cpu_c_oe),
    .lane_out    (lane_out),
    .all_stopped (all_stopped),
    .pll_en      (pll_en),
    .osc_en      (osc_en),
    .mode_park   (mode_park),
    .fs_sel      (fs_sel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (40) @(negedge cpu_clk);
  endtask

  task automatic measure();
    for (int j = 0; j < N; j++) snap[j] = lcnt[j];
    csnap = ccnt;
    repeat (30) @(negedge cpu_clk);
    for (int j = 0; j < N; j++) dif[j] = lcnt[j] - snap[j];
    cdif = ccnt - csnap;
  endtask

  task automatic check_lanes(input logic [N-1:0] exp, input string req);
    for (int j = 0; j < N; j++) begin
      if (exp[j]) chk(dif[j] >= 2, req, $sformatf("lane%0d edges", j), dif[j], 2);
      else chk(dif[j] == 0 && lane_out[j] == 1'b0, req,
               $sformatf("lane%0d stopped edges", j), dif[j], 0);
    end
  endtask

  task automatic do_reset(input bit mode, input logic [FSW-1:0] fs);
    mon = 1'b0;
    rst = 1'b1;
    strap_mode = mode;
    strap_fs = fs;
    pwrgd_n = 1'b1;
    pd_n = 1'b1;
    lane_en = '1;
    cpu_en = 1'b1;
    park_hiz = 1'b0;
    repeat (20) @(negedge cpu_clk);
    rst = 1'b0;
    @(negedge cpu_clk);
    mon = 1'b1;
  endtask

  initial begin : watchdog
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // Reset state, low-stop style
    rst = 1'b1;
    strap_mode = 1'b0;
    strap_fs = 4'h9;
    repeat (20) @(negedge cpu_clk);
    chk(lane_out == '0, "R11", "reset lanes low", int'(lane_out), 0);
    chk(all_stopped == 1'b1, "R11", "reset all_stopped", int'(all_stopped), 1);
    chk(pll_en && osc_en, "R5", "reset pll/osc on", int'({pll_en, osc_en}), 3);
    chk(cpu_t == 1'b0, "R5", "reset cpu_t low", int'(cpu_t), 0);
    rst = 1'b0;
    @(negedge cpu_clk);
    mon = 1'b1;

    // R10: straps captured at reset, power-good ignored
    chk(mode_park == 1'b0, "R8", "mode after reset", int'(mode_park), 0);
    chk(fs_sel == 4'h9, "R10", "fs after reset", int'(fs_sel), 9);
    strap_fs = 4'h3;
    strap_mode = 1'b1;
    pwrgd_n = 1'b0;
    settle();
    measure();
    chk(fs_sel == 4'h9, "R10", "fs after pwrgd edge", int'(fs_sel), 9);
    chk(mode_park == 1'b0, "R8", "mode after strap change", int'(mode_park), 0);
    check_lanes('1, "R10");

    // Table walk
    for (int v = 0; v < NV; v++) begin
      lane_en = VEC[v][15:10];
      cpu_en = VEC[v][9];
      pd_n = VEC[v][8];
      settle();
      measure();
      check_lanes(VEC[v][7:2], VEC[v][8] ? "R4" : "R5");
      if (VEC[v][1]) chk(cdif >= 2, "R12", $sformatf("vec%0d cpu edges", v), cdif, 2);
      else chk(cdif == 0 && cpu_t == 1'b0 && cpu_c == 1'b0 && cpu_t_oe && cpu_c_oe,
               "R12", $sformatf("vec%0d cpu low driven", v), cdif, 0);
      chk(all_stopped == VEC[v][0], "R11", $sformatf("vec%0d all_stopped", v),
          int'(all_stopped), int'(VEC[v][0]));
    end
    lane_en = '1;
    cpu_en = 1'b1;
    pd_n = 1'b1;
    settle();

    // R1: single low sample is ignored
    @(negedge cpu_clk);
    pd_n = 1'b0;
    @(negedge cpu_clk);
    pd_n = 1'b1;
    measure();
    check_lanes('1, "R1");
    chk(all_stopped == 1'b0 && pll_en, "R1", "no stop after one low", int'(all_stopped), 0);

    // R5: low-stop power-down parks all low, PLL and oscillator off
    pd_n = 1'b0;
    settle();
    chk(cpu_t == 0 && cpu_c == 0 && cpu_t_oe && cpu_c_oe, "R5", "cpu pair low driven",
        int'({cpu_t, cpu_c, cpu_t_oe, cpu_c_oe}), 3);
    chk(pll_en == 1'b0, "R5", "pll off", int'(pll_en), 0);
    chk(osc_en == 1'b0, "R5", "osc off", int'(osc_en), 0);

    // R2: single high sample keeps everything stopped
    @(negedge cpu_clk);
    pd_n = 1'b1;
    @(negedge cpu_clk);
    pd_n = 1'b0;
    measure();
    check_lanes('0, "R2");
    chk(cdif == 0, "R2", "cpu stays stopped", cdif, 0);

    pd_n = 1'b1;
    settle();
    chk(pll_en && osc_en, "R5", "pll/osc back on", int'({pll_en, osc_en}), 3);
    measure();
    check_lanes('1, "R3");
    chk(cdif >= 2, "R3", "cpu restarted", cdif, 2);

    // R9: park style waits for power-good
    do_reset(1'b1, 4'hA);
    chk(mode_park == 1'b1, "R8", "park style latched", int'(mode_park), 1);
    strap_mode = 1'b0;
    settle();
    measure();
    check_lanes('0, "R9");
    chk(cdif == 0 && all_stopped, "R9", "held before power-good", cdif, 0);
    strap_fs = 4'h5;
    pwrgd_n = 1'b0;
    settle();
    chk(fs_sel == 4'h5, "R9", "fs at power-good", int'(fs_sel), 5);
    chk(mode_park == 1'b1, "R8", "park style kept", int'(mode_park), 1);
    measure();
    check_lanes('1, "R9");
    strap_fs = 4'h3;
    pwrgd_n = 1'b1;
    settle();
    pwrgd_n = 1'b0;
    settle();
    chk(fs_sel == 4'h5, "R9", "later power-good ignored", int'(fs_sel), 5);

    // R6: park with true line high, complement released
    pd_n = 1'b0;
    settle();
    measure();
    check_lanes('0, "R6");
    chk(cpu_t == 1'b1 && cpu_t_oe == 1'b1, "R6", "cpu_t parked high",
        int'({cpu_t, cpu_t_oe}), 3);
    chk(cpu_c_oe == 1'b0, "R6", "cpu_c released", int'(cpu_c_oe), 0);
    chk(pll_en == 1'b1, "R6", "pll stays on", int'(pll_en), 1);
    chk(all_stopped == 1'b1, "R11", "parked counts as stopped", int'(all_stopped), 1);

    // R7: both lines released
    pd_n = 1'b1;
    settle();
    park_hiz = 1'b1;
    pd_n = 1'b0;
    settle();
    chk(cpu_t_oe == 1'b0 && cpu_c_oe == 1'b0, "R7", "both released",
        int'({cpu_t_oe, cpu_c_oe}), 0);
    pd_n = 1'b1;
    settle();
    measure();
    chk(cdif >= 2 && cpu_t_oe && cpu_c_oe, "R3", "cpu restart after park", cdif, 2);

    // R3: pulse widths across every stop and restart
    begin
      int tot;
      tot = cviol;
      for (int j = 0; j < N; j++) tot += viol[j];
      chk(tot == 0, "R3", "short pulses", tot, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule